// File: doc/BRIEF.md
# Serial Receiver with Status Queue

This block turns an asynchronous serial line into characters. A 16-per-bit sample enable paces it. The line passes through a two-flop synchroniser first. A falling level seen on a sample tick marks a possible start bit, and the block confirms it near the middle of that bit. It then collects 5 to 8 data bits, least significant first, and an optional parity bit, and checks the first stop bit. Each finished character goes into a three-entry queue with its own parity-error, framing-error and break flags. The queue is read through a pop strobe.

Status can be shown two ways. In per-character mode the flags belong to the head entry only. In accumulated mode they also keep the flags of every entry popped since the last error-clear strobe. In the address-wake setting the parity position carries an address/data marker, and a disabled receiver keeps only address characters. An optional flow-control output tells the far end to stop sending when a new character begins while the queue is full. Level inputs hold the configuration, and single-cycle strobes carry the commands.

Top module: `serial_rx_queue`

## Requirements
- R1: The synchronised line is examined only on cycles where `tick16` is 1. A low sample after a high one starts a candidate. The line is sampled again 7 ticks later. If it is high there, the candidate is dropped, nothing is loaded, and the search starts again.
- R2: After a confirmed start, one sample is taken every 16 ticks. `data_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first, and unused upper bits of `rd_data` read 0.
- R3: `par_mode` 00 checks parity: even when `par_odd`=0 and odd when `par_odd`=1. Code 01 expects the parity bit to equal `par_odd`. Code 10 means no parity bit. A mismatch sets the entry's parity-error flag.
- R4: A low first stop bit sets the entry's framing-error flag. The receiver then waits for a high line before it looks for a new start.
- R5: A character that is low throughout, including parity and stop, loads exactly one all-zero entry with both break and framing-error set. No other character is loaded until the line has been high.
- R6: The queue holds 3 entries. `rx_rdy` is 1 while it holds at least one entry, and `ffull` is 1 when it holds 3. `pop` removes the head. `rd_data` shows the head data, or 0 when the queue is empty.
- R7: A character that completes while the queue is full is dropped and sets `overrun`. The flag stays set until `err_reset`.
- R8: With `block_mode`=0, the status outputs show the head entry's flags, or 0 when the queue is empty. With `block_mode`=1, they are the OR of those flags and the flags of every entry popped since the last `err_reset`.
- R9: `par_mode` 11 is address-wake. The bit after the data is stored in the parity-error position. With `rx_on`=0 the line is still decoded, but only characters whose marker is 1 are loaded. With `rx_on`=1 every character is loaded.
- R10: With `auto_rts`=1, `rts_active` drops when a start bit is confirmed while the queue is full. It returns one cycle after the queue stops being full. With `auto_rts`=0 it stays 1.
- R11: Outside address-wake, `rx_on`=0 aborts the character being assembled at once. The entries already queued stay readable.
- R12: A `rx_reset` strobe empties the queue so that `rx_rdy`, `ffull` and the head status read 0. It also drops any partial character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| rx_on | input | 1 | Receiver enable |
| data_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 00 checked, 01 forced, 10 none, 11 address-wake |
| par_odd | input | 1 | Odd parity / forced value |
| block_mode | input | 1 | Accumulated status reporting |
| auto_rts | input | 1 | Automatic flow-control enable |
| pop | input | 1 | Remove head entry |
| rx_reset | input | 1 | Receiver reset strobe |
| err_reset | input | 1 | Clear accumulated status and overrun |
| rd_data | output | 8 | Head entry data |
| rx_rdy | output | 1 | Queue not empty |
| ffull | output | 1 | Queue full |
| st_perr | output | 1 | Parity error / address marker |
| st_ferr | output | 1 | Framing error |
| st_brk | output | 1 | Break received |
| overrun | output | 1 | Sticky overrun |
| rts_active | output | 1 | Flow control: far end may send |

## Verification
The receiver is fed clean 8-bit and 5-bit frames, which shows whether bits are ordered and counted correctly. Frames with correct and wrong parity in checked and forced modes separate the three parity codes. A short low glitch, a stop bit held low and a line held low for a long time separate start rejection, framing error and break. Filling the queue past capacity, both with and without flow control, separates overrun from RTS behaviour. Address-wake frames with the receiver on and off, a mid-frame disable and a receiver reset with entries queued cover the command paths. A behavioural model compares every output on every clock.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rx_on,
  input  logic [1:0] data_len,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  input  logic       block_mode,
  input  logic       auto_rts,
  input  logic       pop,
  input  logic       rx_reset,
  input  logic       err_reset,
  output logic [7:0] rd_data,
  output logic       rx_rdy,
  output logic       ffull,
  output logic       st_perr,
  output logic       st_ferr,
  output logic       st_brk,
  output logic       overrun,
  output logic       rts_active
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
  localparam logic [PW-1:0] FULL_C = PW'(DEPTH);

  typedef enum logic [1:0] {S_WAITHI, S_IDLE, S_START, S_BITS} st_t;

  st_t         st;
  logic        s1, s2, pbit, ovr, rts_neg;
  logic [3:0]  cnt, idx;
  logic [7:0]  sh;
  logic [10:0] mem [0:DEPTH-1];
  logic [PW-1:0] wp, rp, cnt_q;
  logic [2:0]  acc;

  wire wake     = par_mode == 2'b11;
  wire has_par  = par_mode != 2'b10;
  wire run      = (rx_on | wake) & ~rx_reset;
  wire [3:0] nd   = 4'd5 + {2'b00, data_len};
  wire [3:0] last = nd + {3'b000, has_par};
  wire full     = cnt_q == FULL_C;
  wire start_ok = run && tick16 && st == S_START && cnt == 4'd6 && !s2;
  wire at_stop  = run && tick16 && st == S_BITS && cnt == 4'd15 && idx == last;
  wire par_exp  = ^sh ^ par_odd;
  wire perr_n   = wake ? pbit :
                  (par_mode == 2'b00) ? (pbit != par_exp) :
                  (par_mode == 2'b01) ? (pbit != par_odd) : 1'b0;
  wire is_brk   = !s2 && sh == 8'd0 && !pbit;
  wire keep     = at_stop && (rx_on || pbit);
  wire push     = keep && !full;
  wire ovf      = keep && full;
  wire do_pop   = pop && cnt_q != '0 && !rx_reset;
  wire [10:0] top = mem[rp];
  wire [2:0] head_st = rx_rdy ? top[10:8] : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_WAITHI; cnt <= '0; idx <= '0; sh <= '0; pbit <= 1'b0;
    end else if (!run) begin
      st <= S_WAITHI;
    end else if (tick16) begin
      case (st)
        S_WAITHI: if (s2) st <= S_IDLE;
        S_IDLE:   if (!s2) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == 4'd6) begin
            if (s2) st <= S_IDLE;
            else begin
              st <= S_BITS; cnt <= '0; idx <= '0; sh <= '0; pbit <= 1'b0;
            end
          end else cnt <= cnt + 4'd1;
        default:
          if (cnt == 4'd15) begin
            cnt <= '0;
            idx <= idx + 4'd1;
            if (idx < nd) sh[idx[2:0]] <= s2;
            else if (idx != last) pbit <= s2;
            else st <= s2 ? S_IDLE : S_WAITHI;
          end else cnt <= cnt + 4'd1;
      endcase
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {is_brk, !s2, perr_n, sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_q <= '0; acc <= '0; ovr <= 1'b0; rts_neg <= 1'b0;
    end else begin
      if (rx_reset) begin
        cnt_q <= '0;
        rp    <= wp;
      end else begin
        if (push)   wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
        if (do_pop) rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
        cnt_q <= cnt_q + PW'(push) - PW'(do_pop);
      end
      acc <= (err_reset ? 3'b000 : acc) | (do_pop ? top[10:8] : 3'b000);
      ovr <= (ovr && !err_reset) || ovf;
      if (!auto_rts)             rts_neg <= 1'b0;
      else if (start_ok && full) rts_neg <= 1'b1;
      else if (!full)            rts_neg <= 1'b0;
    end

  assign rx_rdy     = cnt_q != '0;
  assign ffull      = full;
  assign rd_data    = rx_rdy ? top[7:0] : 8'd0;
  assign {st_brk, st_ferr, st_perr} = head_st | (block_mode ? acc : 3'b000);
  assign overrun    = ovr;
  assign rts_active = !rts_neg;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_reset,
  input logic err_reset,
  input logic block_mode,
  input logic rx_rdy,
  input logic ffull,
  input logic st_perr,
  input logic overrun,
  input logic rts_active
);
  AST_FULL_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ffull) |-> $past(rx_rdy)); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_reset) |=> overrun); // R7

  AST_RXRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!rx_rdy && !ffull)); // R12

  AST_RTS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !ffull |=> rts_active); // R10

  AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && st_perr && !err_reset && !rx_reset) |=> (st_perr || !block_mode)); // R8
endmodule

bind serial_rx_queue serial_rx_queue_chk chk_i (.*);

// File: tb/serial_rx_queue_tb_top.sv
`timescale 1ns/1ps
module serial_rx_queue_tb_top;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1, rx_on = 1;
  logic [1:0] data_len = 2'd3, par_mode = 2'b10;
  logic par_odd = 0, block_mode = 0, auto_rts = 0, pop = 0, rx_reset = 0, err_reset = 0;
  logic [7:0] rd_data;
  logic rx_rdy, ffull, st_perr, st_ferr, st_brk, overrun, rts_active;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R6";

  always #10 clk = ~clk;

  serial_rx_queue dut_i (.*);

  task automatic step; @(posedge clk); #2; endtask

  initial begin
    int tc = 0;
    forever begin step; tick16 = (tc == 3); tc = (tc + 1) % 4; end
  end

  // behavioural reference model
  int ms1 = 1, ms2 = 1, mst = 0, mcnt = 0, midx = 0;
  logic [7:0] msh = 0;
  bit mpb = 0, movr = 0, mneg = 0;
  logic [2:0] macc = 0;
  logic [10:0] q[$];

  always @(posedge clk) begin
    bit line, run, full, sev, sok, ovf, pe, fe, bk;
    int oldn, nd, lst, ones;
    logic [2:0] pst;
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; mst = 0; mcnt = 0; midx = 0; msh = 0; mpb = 0;
      q.delete(); macc = 0; movr = 0; mneg = 0;
    end else begin
      line = (ms2 != 0); oldn = q.size(); full = (oldn == 3); ovf = 0; pst = 0;
      run = (rx_on || par_mode == 2'b11) && !rx_reset;
      nd = 5 + data_len; lst = nd + ((par_mode != 2'b10) ? 1 : 0);
      sev = run && tick16 && mst == 3 && mcnt == 15 && midx == lst;
      sok = run && tick16 && mst == 2 && mcnt == 6 && !line;
      ones = 0;
      for (int i = 0; i < 8; i++) if (msh[i]) ones++;
      case (par_mode)
        2'b11: pe = mpb;
        2'b00: pe = (mpb != ((ones % 2 == 1) ^ par_odd));
        2'b01: pe = (mpb != par_odd);
        default: pe = 0;
      endcase
      fe = !line; bk = !line && msh == 0 && !mpb;
      if (rx_reset) q.delete();
      else begin
        if (pop && oldn > 0) begin pst = q[0][10:8]; void'(q.pop_front()); end
        if (sev && (rx_on || mpb)) begin
          if (full) ovf = 1; else q.push_back({bk, fe, pe, msh});
        end
      end
      macc = (err_reset ? 3'b0 : macc) | pst;
      movr = (movr && !err_reset) || ovf;
      if (!auto_rts) mneg = 0; else if (sok && full) mneg = 1; else if (!full) mneg = 0;
      if (!run) mst = 0;
      else if (tick16) begin
        case (mst)
          0: if (line) mst = 1;
          1: if (!line) begin mst = 2; mcnt = 0; end
          2: if (mcnt == 6) begin
               if (line) mst = 1;
               else begin mst = 3; mcnt = 0; midx = 0; msh = 0; mpb = 0; end
             end else mcnt++;
          default: if (mcnt == 15) begin
               mcnt = 0;
               if (midx < nd) msh[midx] = line;
               else if (midx != lst) mpb = line;
               else mst = line ? 1 : 0;
               midx++;
             end else mcnt++;
        endcase
      end
      ms2 = ms1; ms1 = rxd;
    end
  end

  task automatic chk(string nm, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h at %0t", cur_req, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [2:0] est;
    est = (q.size() != 0 ? q[0][10:8] : 3'b0) | (block_mode ? macc : 3'b0);
    chk("rx_rdy", {7'd0, rx_rdy}, {7'd0, q.size() != 0});
    chk("ffull", {7'd0, ffull}, {7'd0, q.size() == 3});
    chk("rd_data", rd_data, q.size() != 0 ? q[0][7:0] : 8'd0);
    chk("status", {5'd0, st_brk, st_ferr, st_perr}, {5'd0, est});
    chk("overrun", {7'd0, overrun}, {7'd0, movr});
    chk("rts", {7'd0, rts_active}, {7'd0, !mneg});
  end

  task automatic bitt(input logic v); rxd = v; repeat (64) step; endtask

  task automatic send(input logic [7:0] d, input int pb, input logic stopv);
    bitt(0);
    for (int i = 0; i < 5 + data_len; i++) bitt(d[i]);
    if (pb >= 0) bitt(pb[0]);
    bitt(stopv);
    rxd = 1; repeat (128) step;
  endtask

  task automatic pulse_pop; pop = 1; step; pop = 0; repeat (3) step; endtask
  task automatic pulse_err; err_reset = 1; step; err_reset = 0; repeat (3) step; endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog expired", cur_req);
      done = 1;
      finish_run;
    end
  end

  initial begin
    repeat (5) step; rst_n = 1; repeat (20) step;          // R6 reset state
    cur_req = "R2";
    send(8'hA5, -1, 1); send(8'h3C, -1, 1); pulse_pop; pulse_pop;
    data_len = 0; send(8'hF5, -1, 1); pulse_pop; data_len = 3;
    cur_req = "R3";
    par_mode = 2'b00; par_odd = 0;
    send(8'h07, 1, 1); send(8'h07, 0, 1); pulse_pop; pulse_pop;
    par_odd = 1; send(8'h07, 0, 1); send(8'h07, 1, 1); pulse_pop; pulse_pop;
    par_mode = 2'b01; send(8'h00, 0, 1); send(8'h00, 1, 1); pulse_pop; pulse_pop;
    par_mode = 2'b10; par_odd = 0;
    cur_req = "R1";
    rxd = 0; repeat (20) step; rxd = 1; repeat (300) step;
    cur_req = "R4";
    send(8'h5A, -1, 0); send(8'h66, -1, 1); pulse_pop; pulse_pop;
    cur_req = "R5";
    rxd = 0; repeat (15 * 64) step; rxd = 1; repeat (200) step; pulse_pop;
    cur_req = "R7";
    send(8'h01, -1, 1); send(8'h02, -1, 1); send(8'h03, -1, 1); send(8'h04, -1, 1);
    pulse_pop; pulse_pop; pulse_pop; pulse_err;
    cur_req = "R10";
    auto_rts = 1;
    send(8'h11, -1, 1); send(8'h12, -1, 1); send(8'h13, -1, 1); send(8'h14, -1, 1);
    pulse_pop; pulse_pop; pulse_pop; auto_rts = 0; pulse_err;
    cur_req = "R8";
    block_mode = 1; par_mode = 2'b00;
    send(8'h01, 0, 1); send(8'h03, 0, 1); pulse_pop; repeat (10) step; pulse_pop;
    pulse_err; block_mode = 0; par_mode = 2'b10;
    cur_req = "R9";
    par_mode = 2'b11; rx_on = 0;
    send(8'h21, 0, 1); send(8'h22, 1, 1); pulse_pop;
    rx_on = 1; send(8'h23, 0, 1); pulse_pop; par_mode = 2'b10;
    cur_req = "R11";
    send(8'h44, -1, 1);
    bitt(0); bitt(1); bitt(0); bitt(1); rx_on = 0;
    bitt(0); bitt(1); bitt(0); bitt(1); bitt(1); bitt(1);
    repeat (64) step; rx_on = 1; repeat (128) step; pulse_pop;
    cur_req = "R12";
    send(8'h51, -1, 1); send(8'h52, -1, 1);
    rx_reset = 1; step; rx_reset = 0; repeat (10) step;
    send(8'h53, -1, 1); pulse_pop;
    repeat (20) step;
    done = 1;
    finish_run;
  end
endmodule